// File: doc/BRIEF.md
# Machine-Check Global Status and Reporting Control

This block keeps the core-wide machine-check state: three status flags and one reporting enable. Error-bank logic presents error events on a per-bank valid vector, each bank with a restart-valid qualifier and an error-address-valid qualifier. When reporting is on and no machine check is already being handled, an event loads the flags and sends a one-cycle exception request to the core. When an event arrives while the in-progress flag is still set, the block raises a shutdown request instead. That request stays high until reset.

Software reaches both words through a small register port. `reg_sel` chooses the word, `reg_wr_en` writes it, and `reg_rdata` always shows the selected word. The control word exists only when the `CTRL_PRESENT` parameter is 1. When it is absent, reporting is always on.

Top module: `mce_status_ctrl`

## Requirements
- R1: With `reg_sel`=0 the status word is read. Bit 0 is restart-valid, bit 1 is error-address-valid and bit 2 is in-progress. Bits above 2 always read zero, and write data in those bits is dropped.
- R2: An event is any set bit of `evt_vld`. When reporting is on, an event with in-progress clear sets in-progress at the next edge. It also loads bits 0 and 1 from the qualifiers of the lowest-index active bank, and drives `exc_req` high for exactly one cycle after that edge.
- R3: A write with `reg_sel`=0 loads bits 2:0 of `reg_wdata` into the flags, so software can both set and clear in-progress.
- R4: When an accepted event and a status write fall in the same cycle, the event is applied and the write is discarded.
- R5: When reporting is on, an event with in-progress set raises `shutdown_req` at the next edge. It raises no `exc_req` and leaves the flags unchanged.
- R6: `shutdown_req` stays high until reset, whatever later writes or events occur.
- R7: With `CTRL_PRESENT`=1, a write with `reg_sel`=1 behaves as follows. All ones turns reporting on and all zeros turns it off. Any other value leaves the enable unchanged. The word reads as all ones when reporting is on and as zero when it is off.
- R8: While reporting is off, events raise neither `exc_req` nor `shutdown_req` and leave the flags unchanged.
- R9: With `CTRL_PRESENT`=0, the control word reads zero, writes to it have no effect, and reporting is always on.
- R10: Reset (synchronous, active high) clears all flags and both requests, and turns reporting on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_vld | input | NUM_BANKS | Per-bank error event strobe |
| evt_restart_ok | input | NUM_BANKS | Per-bank restart-valid qualifier |
| evt_errip_ok | input | NUM_BANKS | Per-bank error-address-valid qualifier |
| reg_sel | input | 1 | Register select: 0 status, 1 control |
| reg_wr_en | input | 1 | Write strobe for the selected register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Selected register contents |
| exc_req | output | 1 | One-cycle machine-check exception request |
| shutdown_req | output | 1 | Sticky shutdown request on a nested event |

## Verification
The bench builds two copies side by side with `DATA_W`=64 and `NUM_BANKS`=4, one with `CTRL_PRESENT`=1 and one with `CTRL_PRESENT`=0, and feeds both the same stimulus. The first copy covers enable toggling, non-qualifying control values and events that arrive while reporting is off. The second shows the same events raising exceptions with an always-on enable and a control word that reads zero. Four banks make several events in the same cycle possible, so the lowest-index qualifier selection is exercised. A 64-bit data word lets writes of all ones reach the reserved status bits.

// File: rtl/mce_pkg.sv
package mce_pkg;

    localparam int FLAG_W = 3;

    typedef enum logic {
        SEL_STATUS  = 1'b0,
        SEL_CONTROL = 1'b1
    } reg_sel_e;

    // Packed order gives the bit positions that software decodes:
    // in_prog -> bit 2, errip_ok -> bit 1, restart_ok -> bit 0.
    typedef struct packed {
        logic in_prog;
        logic errip_ok;
        logic restart_ok;
    } mc_flags_t;

    typedef struct packed {
        logic hit;
        logic restart_ok;
        logic errip_ok;
    } evt_pick_t;

    function automatic mc_flags_t flags_from_word(input logic [FLAG_W-1:0] w);
        return mc_flags_t'(w);
    endfunction

    function automatic mc_flags_t flags_on_accept(input evt_pick_t p);
        mc_flags_t f;
        f.in_prog    = 1'b1;
        f.errip_ok   = p.errip_ok;
        f.restart_ok = p.restart_ok;
        return f;
    endfunction

endpackage

// File: rtl/mce_evt_select.sv
module mce_evt_select
    import mce_pkg::*;
#(
    parameter int NUM_BANKS = 4
) (
    input  logic [NUM_BANKS-1:0] evt_vld,
    input  logic [NUM_BANKS-1:0] evt_restart_ok,
    input  logic [NUM_BANKS-1:0] evt_errip_ok,
    output evt_pick_t            pick
);

    // Scan from the highest index down so the lowest active bank wins.
    always_comb begin
        pick = '0;
        for (int i = NUM_BANKS - 1; i >= 0; i--) begin
            if (evt_vld[i]) begin
                pick.hit        = 1'b1;
                pick.restart_ok = evt_restart_ok[i];
                pick.errip_ok   = evt_errip_ok[i];
            end
        end
    end

endmodule

// File: rtl/mce_ctl_reg.sv
module mce_ctl_reg #(
    parameter int DATA_W       = 64,
    parameter bit CTRL_PRESENT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic              rep_en,
    output logic [DATA_W-1:0] rd_word
);

    generate
        if (CTRL_PRESENT) begin : g_present
            logic en_q;
            logic all_ones;
            logic all_zeros;

            assign all_ones  = &wdata;
            assign all_zeros = ~|wdata;

            always_ff @(posedge clk) begin
                if (rst) begin
                    en_q <= 1'b1;
                end else if (wr_en && all_ones) begin
                    en_q <= 1'b1;
                end else if (wr_en && all_zeros) begin
                    en_q <= 1'b0;
                end
            end

            assign rep_en  = en_q;
            assign rd_word = {DATA_W{en_q}};

            // R7
            ctl_enable_chk: assert property (@(posedge clk) disable iff (rst)
                (wr_en && all_ones) |=> rep_en);
            // R7
            ctl_disable_chk: assert property (@(posedge clk) disable iff (rst)
                (wr_en && all_zeros) |=> !rep_en);
            // R7
            ctl_hold_chk: assert property (@(posedge clk) disable iff (rst)
                (!wr_en || (!all_ones && !all_zeros)) |=> $stable(rep_en));
        end else begin : g_absent
            logic              unused_wr;
            logic [DATA_W-1:0] unused_data;
            logic              unused_clk_rst;
            assign unused_wr      = wr_en;
            assign unused_data    = wdata;
            assign unused_clk_rst = clk ^ rst;
            assign rep_en  = 1'b1;
            assign rd_word = '0;
        end
    endgenerate

endmodule

// File: rtl/mce_status_reg.sv
module mce_status_reg
    import mce_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  evt_pick_t pick,
    input  logic      rep_en,
    input  logic      wr_en,
    input  mc_flags_t wr_flags,
    output mc_flags_t flags,
    output logic      exc_req,
    output logic      shutdown_req
);

    mc_flags_t flags_q;
    logic      exc_q;
    logic      sd_q;
    logic      accept;

    assign accept = pick.hit && rep_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            exc_q   <= 1'b0;
            sd_q    <= 1'b0;
        end else begin
            exc_q <= 1'b0;
            if (accept) begin
                if (flags_q.in_prog) begin
                    sd_q <= 1'b1;
                end else begin
                    flags_q <= flags_on_accept(pick);
                    exc_q   <= 1'b1;
                end
            end else if (wr_en) begin
                flags_q <= wr_flags;
            end
        end
    end

    assign flags        = flags_q;
    assign exc_req      = exc_q;
    assign shutdown_req = sd_q;

    // R2
    exc_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        exc_req |=> !exc_req);
    // R2
    exc_sets_inprog_chk: assert property (@(posedge clk) disable iff (rst)
        exc_req |-> flags.in_prog);
    // R5
    nested_shutdown_chk: assert property (@(posedge clk) disable iff (rst)
        (pick.hit && rep_en && flags.in_prog) |=> (shutdown_req && !exc_req && $stable(flags)));
    // R6
    shutdown_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        shutdown_req |=> shutdown_req);
    // R8
    disabled_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (!rep_en && !wr_en) |=> ($stable(flags) && !exc_req && $stable(shutdown_req)));
    // R4
    event_over_write_chk: assert property (@(posedge clk) disable iff (rst)
        (pick.hit && rep_en && !flags.in_prog && wr_en) |=> (flags.in_prog && exc_req));

endmodule

// File: rtl/mce_status_ctrl.sv
module mce_status_ctrl
    import mce_pkg::*;
#(
    parameter int DATA_W       = 64,
    parameter int NUM_BANKS    = 4,
    parameter bit CTRL_PRESENT = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_BANKS-1:0] evt_vld,
    input  logic [NUM_BANKS-1:0] evt_restart_ok,
    input  logic [NUM_BANKS-1:0] evt_errip_ok,
    input  logic                 reg_sel,
    input  logic                 reg_wr_en,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    output logic                 exc_req,
    output logic                 shutdown_req
);

    localparam int RSV_W = DATA_W - FLAG_W;

    reg_sel_e          sel;
    evt_pick_t         pick;
    mc_flags_t         flags;
    logic              rep_en;
    logic [DATA_W-1:0] ctl_word;
    logic              wr_status;
    logic              wr_control;

    assign sel        = reg_sel_e'(reg_sel);
    assign wr_status  = reg_wr_en && (sel == SEL_STATUS);
    assign wr_control = reg_wr_en && (sel == SEL_CONTROL);

    mce_evt_select #(
        .NUM_BANKS(NUM_BANKS)
    ) u_select (
        .evt_vld       (evt_vld),
        .evt_restart_ok(evt_restart_ok),
        .evt_errip_ok  (evt_errip_ok),
        .pick          (pick)
    );

    mce_ctl_reg #(
        .DATA_W      (DATA_W),
        .CTRL_PRESENT(CTRL_PRESENT)
    ) u_ctl (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_control),
        .wdata  (reg_wdata),
        .rep_en (rep_en),
        .rd_word(ctl_word)
    );

    mce_status_reg u_status (
        .clk         (clk),
        .rst         (rst),
        .pick        (pick),
        .rep_en      (rep_en),
        .wr_en       (wr_status),
        .wr_flags    (flags_from_word(reg_wdata[FLAG_W-1:0])),
        .flags       (flags),
        .exc_req     (exc_req),
        .shutdown_req(shutdown_req)
    );

    always_comb begin
        if (sel == SEL_STATUS) begin
            reg_rdata = {{RSV_W{1'b0}}, flags};
        end else begin
            reg_rdata = ctl_word;
        end
    end

endmodule

// File: tb/mce_status_ctrl_tb_top.sv
module mce_status_ctrl_tb_top;
    localparam int DW = 64;
    localparam int NB = 4;

    logic clk = 1'b0;
    logic rst;
    always #2 clk = ~clk;

    logic [NB-1:0] evt, qr, qe;
    logic          sel, wr;
    logic [DW-1:0] wd;
    logic          exc_a, sd_a, exc_b, sd_b;
    logic [DW-1:0] rd_a, rd_b;

    mce_status_ctrl #(.DATA_W(DW), .NUM_BANKS(NB), .CTRL_PRESENT(1'b1)) dut_i (
        .clk(clk), .rst(rst), .evt_vld(evt), .evt_restart_ok(qr), .evt_errip_ok(qe),
        .reg_sel(sel), .reg_wr_en(wr), .reg_wdata(wd), .reg_rdata(rd_a),
        .exc_req(exc_a), .shutdown_req(sd_a));

    mce_status_ctrl #(.DATA_W(DW), .NUM_BANKS(NB), .CTRL_PRESENT(1'b0)) dut_abs_i (
        .clk(clk), .rst(rst), .evt_vld(evt), .evt_restart_ok(qr), .evt_errip_ok(qe),
        .reg_sel(sel), .reg_wr_en(wr), .reg_wdata(wd), .reg_rdata(rd_b),
        .exc_req(exc_b), .shutdown_req(sd_b));

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    bit [2:0] mfl [2];
    bit       men [2];
    bit       msd [2];
    bit       mexc[2];

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic void model_step(input int k, input bit present);
        bit en;
        int pk;
        if (rst) begin
            mfl[k] = 3'b000; men[k] = 1'b1; msd[k] = 1'b0; mexc[k] = 1'b0;
            return;
        end
        en = present ? men[k] : 1'b1;
        pk = -1;
        for (int i = NB - 1; i >= 0; i--) if (evt[i]) pk = i;
        mexc[k] = 1'b0;
        if (pk >= 0 && en) begin
            if (mfl[k][2]) msd[k] = 1'b1;
            else begin
                mfl[k]  = {1'b1, qe[pk], qr[pk]};
                mexc[k] = 1'b1;
            end
        end else if (wr && !sel) begin
            mfl[k] = wd[2:0];
        end
        if (present && wr && sel) begin
            if (wd == {DW{1'b1}}) men[k] = 1'b1;
            else if (wd == '0) men[k] = 1'b0;
        end
    endfunction

    function automatic logic [DW-1:0] exp_rd(input int k, input bit present);
        if (!sel) return {{(DW-3){1'b0}}, mfl[k]};
        return present ? {DW{men[k]}} : '0;
    endfunction

    task automatic cycle();
        @(posedge clk);
        #1;
        model_step(0, 1'b1);
        model_step(1, 1'b0);
        chk("R2 exc_req (present)", exc_a, mexc[0]);
        chk("R5 shutdown_req (present)", sd_a, msd[0]);
        chk(sel ? "R7 control read" : "R1 status read", rd_a, exp_rd(0, 1'b1));
        chk("R2 exc_req (absent)", exc_b, mexc[1]);
        chk("R5 shutdown_req (absent)", sd_b, msd[1]);
        chk(sel ? "R9 control read (absent)" : "R1 status read (absent)", rd_b, exp_rd(1, 1'b0));
    endtask

    task automatic idle();
        evt = '0; qr = '0; qe = '0; wr = 1'b0; wd = '0;
    endtask

    task automatic wreg(input logic s, input logic [DW-1:0] d);
        idle(); sel = s; wr = 1'b1; wd = d;
        cycle();
        wr = 1'b0;
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        idle(); sel = 1'b0; rst = 1'b1;
        #1;
        cycle(); cycle();
        rst = 1'b0;
        cycle();
        // R10 reset state
        chk("R10 status after reset", rd_a, '0);
        chk("R10 no requests after reset", {62'd0, exc_a, sd_a}, '0);
        sel = 1'b1; #1;
        chk("R10 reporting enabled after reset", rd_a, {DW{1'b1}});

        // R7 non-qualifying value keeps enable
        wreg(1'b1, 64'h5);
        chk("R7 other value keeps enable", rd_a, {DW{1'b1}});
        wreg(1'b1, '0);
        chk("R7 zeros disable", rd_a, '0);
        chk("R9 absent control reads zero", rd_b, '0);
        // R8 event while disabled
        idle(); sel = 1'b0; evt = 4'b0001; qr = 4'b0001;
        cycle();
        chk("R8 no exception when disabled", exc_a, 1'b0);
        chk("R9 absent copy still reports", exc_b, 1'b1);
        idle(); cycle();
        chk("R8 status untouched when disabled", rd_a, '0);
        wreg(1'b0, 64'h0); // clear absent copy
        wreg(1'b1, {DW{1'b1}});
        chk("R7 ones enable", rd_a, {DW{1'b1}});

        // R2 lowest active bank supplies the qualifiers
        idle(); sel = 1'b0; evt = 4'b0110; qr = 4'b0010; qe = 4'b0100;
        cycle();
        chk("R2 exception pulse", exc_a, 1'b1);
        chk("R2 flags from bank 1", rd_a, 64'h5);
        idle(); cycle();
        chk("R2 pulse lasts one cycle", exc_a, 1'b0);

        // R5 nested event
        evt = 4'b1000; qr = 4'b1000; qe = 4'b1000;
        cycle();
        chk("R5 shutdown on nested event", sd_a, 1'b1);
        chk("R5 no exception on nested event", exc_a, 1'b0);
        chk("R5 flags unchanged", rd_a, 64'h5);
        // R6 sticky, R3 software clear
        wreg(1'b0, 64'h0);
        chk("R3 software clears in-progress", rd_a, '0);
        idle(); cycle(); cycle();
        chk("R6 shutdown stays set", sd_a, 1'b1);

        // R1 reserved bits, R3 set flags
        wreg(1'b0, {DW{1'b1}});
        chk("R1 reserved bits read zero", rd_a, 64'h7);
        wreg(1'b0, 64'h2);
        chk("R3 write loads flags", rd_a, 64'h2);

        // R4 event beats write in the same cycle
        idle(); sel = 1'b0; wr = 1'b1; wd = 64'h0; evt = 4'b0100; qr = 4'b0100; qe = 4'b0000;
        cycle();
        chk("R4 event wins over write", rd_a, 64'h5);
        chk("R4 exception raised", exc_a, 1'b1);

        // reset again, then random traffic
        idle(); rst = 1'b1; cycle(); rst = 1'b0; cycle();
        chk("R6 shutdown cleared only by reset", sd_a, 1'b0);
        for (int n = 0; n < 4000; n++) begin
            int r;
            r   = $urandom_range(0, 99);
            evt = (r < 20) ? NB'($urandom) : '0;
            qr  = NB'($urandom);
            qe  = NB'($urandom);
            sel = 1'($urandom);
            wr  = ($urandom_range(0, 9) < 3);
            case ($urandom_range(0, 3))
                0: wd = '0;
                1: wd = {DW{1'b1}};
                2: wd = {$urandom, $urandom};
                default: wd = 64'($urandom_range(0, 7));
            endcase
            if ($urandom_range(0, 499) == 0) rst = 1'b1; else rst = 1'b0;
            cycle();
        end
        rst = 1'b0;

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule